// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block takes 32-bit audio words from a small internal FIFO and shifts them out on one serial data line. It produces its own bit clock and frame clock, so it always acts as the clock master. A frame holds either two slots in stereo mode or an even number of slots in multi-slot mode. An enable mask chooses which slots carry samples. Slots that are masked off stay low and do not consume FIFO words.

Each written word carries its sample left-aligned. The configured sample depth sets how many of the top bits are sent, MSB first, and the rest of the slot is filled with zeros. Sample depth and slot length are configured separately. Two framing rules are available: data that starts at the frame clock edge, or data that starts one bit later. Software loads the FIFO, sets the configuration, and then raises `enable`. Dropping `enable` lets the current frame finish, after which the serial pins go low.

Top module: `tdm_serial_tx`

## Requirements
- R1: Out of reset, `bclk`, `fclk`, `sd` and `underflow` are low and `fifo_level` is 0.
- R2: While running, `bclk` starts low and toggles every `cfg_div`+1 system clocks. One bit period is therefore 2×(`cfg_div`+1) clocks. Data and frame clock change only on its falling edge.
- R3: A frame is slots × slot-length bit periods. The slot count is 2 when `cfg_tdm`=0 and `cfg_slots` when `cfg_tdm`=1. The slot length is 16 bits when `cfg_slot32`=0 and 32 bits when it is 1.
- R4: For the first half of a frame's slots, `fclk` equals `cfg_frame_rise`. For the second half it is the inverse. It is low while idle.
- R5: In an enabled slot, bit k of the slot (k=0 first) carries word bit 31−k when k is less than the depth, and 0 otherwise. `cfg_dsize` selects the depth: 0 means 16, 1 means 24, 2 means 32.
- R6: With `cfg_i2s_delay`=0 the first sample bit lines up with the start of its slot. With `cfg_i2s_delay`=1, `sd` lags that stream by one bit period, and the first bit after starting is 0.
- R7: A slot whose `cfg_mask` bit is 0 drives `sd` low, apart from the delayed bit in R6, and does not pop the FIFO. An enabled slot pops exactly one word as it starts.
- R8: If an enabled slot starts while the FIFO is empty, that slot sends zeros and `underflow` goes high. It stays high until reset.
- R9: A write while `fifo_level` equals the depth is dropped. `fifo_level` reports the number of stored words, and the words come out in write order.
- R10: When `enable` is low at the end of a frame, the block stops at that frame boundary. `bclk`, `fclk` and `sd` then stay low until the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Start, or keep running; a low level stops at the frame end |
| wr_valid | input | 1 | Write strobe for the FIFO |
| wr_data | input | 32 | Sample word, left-aligned |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | Words held in the FIFO |
| cfg_i2s_delay | input | 1 | 0: data at the frame edge, 1: one-bit delay |
| cfg_dsize | input | 2 | Sample depth code |
| cfg_slot32 | input | 1 | Slot length 16 or 32 bits |
| cfg_tdm | input | 1 | Multi-slot mode |
| cfg_slots | input | $clog2(MAX_SLOTS+1) | Slot count in multi-slot mode |
| cfg_mask | input | MAX_SLOTS | Per-slot enable |
| cfg_frame_rise | input | 1 | Frame clock level during the first half of the frame |
| cfg_div | input | DIV_W | Half bit-period minus one, in system clocks |
| underflow | output | 1 | Sticky FIFO-empty flag |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| sd | output | 1 | Serial data |

## Verification
The assertions rely on three things about the inputs. The configuration does not change while the block runs. The slot count is even and lies between 2 and the maximum. The mask is not all zeros. The stimulus only changes configuration after a reset, with `enable` low. It uses even slot counts only, and it always leaves at least one slot enabled. Each scenario ends by lowering `enable` in the middle of its last frame, so that the block is idle before the next reconfiguration.

// File: rtl/tdm_tx_pkg.sv
// Shared types and helpers for the TDM serial transmitter.
package tdm_tx_pkg;
    typedef enum logic [1:0] {
        DS_16 = 2'd0,
        DS_24 = 2'd1,
        DS_32 = 2'd2
    } dsize_e;

    // Number of sample bits for a depth code.
    function automatic logic [5:0] depth_bits(input logic [1:0] code);
        case (dsize_e'(code))
            DS_16:   return 6'd16;
            DS_24:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/tdm_tx_fifo.sv
// Sample FIFO. Assumes DEPTH is a power of two.
// A push is dropped when the FIFO is full. The reader pops only when it is not empty.
module tdm_tx_fifo #(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [31:0]                  din_i,
    input  logic                         pop_i,
    output logic [31:0]                  head_o,
    output logic                         empty_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [31:0]   mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] count;
    logic          push_ok;

    assign push_ok = push_i && (count != LW'(DEPTH));
    assign empty_o = (count == '0);
    assign head_o  = mem[rptr];
    assign level_o = count;

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din_i;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + AW'(1);
            if (pop_i)   rptr <= rptr + AW'(1);
            count <= count + LW'(push_ok) - LW'(pop_i);
        end
    end

    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == LW'(DEPTH)) && !pop_i |=> (count == LW'(DEPTH)));
endmodule

// File: rtl/tdm_tx_bitclk.sv
// Bit clock divider. While run_i is high, bclk toggles every div_i+1 clocks.
// While run_i is low, it is held low with the count cleared.
// fall_o marks the cycle in which bclk goes from high to low.
module tdm_tx_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             bclk_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt;

    assign fall_o = run_i && bclk_o && (cnt == div_i);

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt    <= '0;
            bclk_o <= 1'b0;
        end else if (cnt == div_i) begin
            cnt    <= '0;
            bclk_o <= ~bclk_o;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    p_bclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !bclk_o);
endmodule

// File: rtl/tdm_tx_framer.sv
// Frame sequencer. Tracks the slot and bit position, loads a sample at each slot start,
// and forms sd and fclk. It assumes the configuration is stable while running,
// the slot count is even and within 2..MAX_SLOTS, and the mask is non-zero.
module tdm_tx_framer #(
    parameter int MAX_SLOTS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable_i,
    input  logic                           fall_i,
    input  logic                           i2s_delay_i,
    input  logic [1:0]                     dsize_i,
    input  logic                           slot32_i,
    input  logic                           tdm_i,
    input  logic [$clog2(MAX_SLOTS+1)-1:0] slots_i,
    input  logic [MAX_SLOTS-1:0]           mask_i,
    input  logic                           frame_rise_i,
    input  logic                           empty_i,
    input  logic [31:0]                    head_i,
    output logic                           pop_o,
    output logic                           running_o,
    output logic                           underflow_o,
    output logic                           fclk_o,
    output logic                           sd_o
);
    import tdm_tx_pkg::*;

    localparam int SW = $clog2(MAX_SLOTS + 1);
    localparam int IW = $clog2(MAX_SLOTS);

    logic          running, dly, uflow;
    logic [IW-1:0] slot, nslot;
    logic [4:0]    bitn;
    logic [31:0]   hold;
    logic [SW-1:0] nsl;
    logic          last_b, last_s, enter, want, cur_bit;

    assign nsl     = tdm_i ? slots_i : SW'(2);
    assign last_b  = slot32_i ? (bitn == 5'd31) : (bitn == 5'd15);
    assign last_s  = (SW'(slot) == nsl - SW'(1));
    assign cur_bit = ({1'b0, bitn} < depth_bits(dsize_i)) ? hold[5'd31 - bitn] : 1'b0;

    // Choose when a new slot begins, and which one.
    always_comb begin
        enter = 1'b0;
        nslot = '0;
        if (!running) begin
            enter = enable_i;
        end else if (fall_i && last_b && !(last_s && !enable_i)) begin
            enter = 1'b1;
            nslot = last_s ? '0 : slot + IW'(1);
        end
    end

    assign want  = enter && mask_i[nslot];
    assign pop_o = want && !empty_i;

    // Position, sample holding register, delayed bit and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            slot    <= '0;
            bitn    <= '0;
            hold    <= '0;
            dly     <= 1'b0;
            uflow   <= 1'b0;
        end else begin
            if (want && empty_i) uflow <= 1'b1;
            if (enter) hold <= pop_o ? head_i : 32'd0;
            if (!running) begin
                if (enable_i) begin
                    running <= 1'b1;
                    slot    <= '0;
                    bitn    <= '0;
                    dly     <= 1'b0;
                end
            end else if (fall_i) begin
                if (last_b && last_s && !enable_i) begin
                    running <= 1'b0;
                    slot    <= '0;
                    bitn    <= '0;
                    dly     <= 1'b0;
                    hold    <= '0;
                end else begin
                    dly  <= cur_bit;
                    bitn <= last_b ? 5'd0 : bitn + 5'd1;
                    if (last_b) slot <= nslot;
                end
            end
        end
    end

    assign running_o   = running;
    assign underflow_o = uflow;
    assign fclk_o = running && ((SW'(slot) < (nsl >> 1)) ? frame_rise_i : !frame_rise_i);
    assign sd_o   = running && (i2s_delay_i ? dly : cur_bit);

    p_uflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);
    p_fclk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running && !fall_i |=> $stable(fclk_o));
    p_stop_at_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        running && fall_i && last_b && last_s && !enable_i |=> !running_o && !fclk_o && !sd_o);
    p_masked_nopop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |-> enter);
endmodule

// File: rtl/tdm_serial_tx.sv
// TDM/stereo serial audio transmitter, clock master. Connects the FIFO, the bit clock
// divider and the frame sequencer. The configuration must stay stable while enabled.
module tdm_serial_tx #(
    parameter int FIFO_DEPTH = 8,
    parameter int MAX_SLOTS  = 8,
    parameter int DIV_W      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              enable,
    input  logic                              wr_valid,
    input  logic [31:0]                       wr_data,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_level,
    input  logic                              cfg_i2s_delay,
    input  logic [1:0]                        cfg_dsize,
    input  logic                              cfg_slot32,
    input  logic                              cfg_tdm,
    input  logic [$clog2(MAX_SLOTS+1)-1:0]    cfg_slots,
    input  logic [MAX_SLOTS-1:0]              cfg_mask,
    input  logic                              cfg_frame_rise,
    input  logic [DIV_W-1:0]                  cfg_div,
    output logic                              underflow,
    output logic                              bclk,
    output logic                              fclk,
    output logic                              sd
);
    logic        pop, empty, running, fall;
    logic [31:0] head;

    tdm_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(wr_valid), .din_i(wr_data),
        .pop_i(pop), .head_o(head), .empty_o(empty), .level_o(fifo_level)
    );

    tdm_tx_bitclk #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst_n(rst_n), .run_i(running), .div_i(cfg_div),
        .bclk_o(bclk), .fall_o(fall)
    );

    tdm_tx_framer #(.MAX_SLOTS(MAX_SLOTS)) u_framer (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .fall_i(fall),
        .i2s_delay_i(cfg_i2s_delay), .dsize_i(cfg_dsize), .slot32_i(cfg_slot32),
        .tdm_i(cfg_tdm), .slots_i(cfg_slots), .mask_i(cfg_mask),
        .frame_rise_i(cfg_frame_rise), .empty_i(empty), .head_i(head),
        .pop_o(pop), .running_o(running), .underflow_o(underflow),
        .fclk_o(fclk), .sd_o(sd)
    );
endmodule

// File: tb/sim_tdm_serial_tx.sv
module sim_tdm_serial_tx;
    localparam int DEPTH = 8;
    localparam int MAXS  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0] fifo_level;
    logic c_i2s = 1'b0, c_slot32 = 1'b0, c_tdm = 1'b0, c_rise = 1'b1;
    logic [1:0] c_dsize = 2'd0;
    logic [3:0] c_slots = 4'd2;
    logic [7:0] c_mask = 8'h03, c_div = 8'd1;
    logic underflow, bclk, fclk, sd;

    always #10 clk = ~clk;

    tdm_serial_tx u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_valid(wr_valid), .wr_data(wr_data),
        .fifo_level(fifo_level), .cfg_i2s_delay(c_i2s), .cfg_dsize(c_dsize),
        .cfg_slot32(c_slot32), .cfg_tdm(c_tdm), .cfg_slots(c_slots), .cfg_mask(c_mask),
        .cfg_frame_rise(c_rise), .cfg_div(c_div), .underflow(underflow),
        .bclk(bclk), .fclk(fclk), .sd(sd)
    );

    int checks = 0, errors = 0, cyc = 0, rises = 0;
    bit done = 0, cmp_on = 0, bclk_prev = 0;
    string sd_tag = "R5 sd";

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Behavioural reference model.
    logic [31:0] m_q[$];
    bit m_run, m_bclk, m_dly, m_uf;
    int m_cnt, m_s, m_b;
    logic [31:0] m_hold;

    function automatic int f_len();   return c_slot32 ? 32 : 16; endfunction
    function automatic int f_nsl();   return c_tdm ? int'(c_slots) : 2; endfunction
    function automatic int f_depth(); return c_dsize == 0 ? 16 : (c_dsize == 1 ? 24 : 32); endfunction

    task automatic m_enter(int ns);
        if (c_mask[ns]) begin
            if (m_q.size() > 0) m_hold = m_q.pop_front();
            else begin m_hold = 0; m_uf = 1; end
        end else m_hold = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_q.delete(); m_run = 0; m_bclk = 0; m_dly = 0; m_uf = 0;
            m_cnt = 0; m_s = 0; m_b = 0; m_hold = 0;
        end else begin
            int L, nsl, db;
            bit wr_ok, fall, cur, old_run;
            logic [31:0] wd;
            L = f_len(); nsl = f_nsl(); db = f_depth();
            wr_ok = wr_valid && (m_q.size() < DEPTH);
            wd = wr_data;
            fall = m_run && m_bclk && (m_cnt == int'(c_div));
            cur = (m_b < db) ? m_hold[31 - m_b] : 1'b0;
            old_run = m_run;
            if (!m_run) begin
                if (enable) begin m_run = 1; m_s = 0; m_b = 0; m_dly = 0; m_enter(0); end
            end else if (fall) begin
                if (m_b == L - 1 && m_s == nsl - 1 && !enable) begin
                    m_run = 0; m_s = 0; m_b = 0; m_dly = 0; m_hold = 0;
                end else begin
                    m_dly = cur;
                    if (m_b == L - 1) begin
                        m_b = 0;
                        m_s = (m_s == nsl - 1) ? 0 : m_s + 1;
                        m_enter(m_s);
                    end else m_b++;
                end
            end
            if (!old_run) begin m_cnt = 0; m_bclk = 0; end
            else if (m_cnt == int'(c_div)) begin m_cnt = 0; m_bclk = !m_bclk; end
            else m_cnt++;
            if (wr_ok) m_q.push_back(wd);
        end
    end

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            bit e_sd, e_fclk;
            e_sd = m_run && (c_i2s ? m_dly :
                   ((m_b < f_depth()) ? m_hold[31 - m_b] : 1'b0));
            e_fclk = m_run && ((m_s < f_nsl() / 2) ? c_rise : !c_rise);
            chk("R2 bclk", bclk, m_bclk);
            chk("R4 fclk", fclk, e_fclk);
            chk(sd_tag, sd, e_sd);
            chk("R9 fifo_level", fifo_level, m_q.size());
            chk("R8 underflow", underflow, m_uf);
        end
        if (bclk && !bclk_prev) rises++;
        bclk_prev = bclk;
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; enable = 0; wr_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic preload(int n);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1; wr_data = $urandom;
            @(negedge clk);
        end
        wr_valid = 0;
    endtask

    task automatic run_frames(int frames);
        int fc, g;
        fc = f_nsl() * f_len() * 2 * (int'(c_div) + 1);
        rises = 0;
        enable = 1;
        repeat ((frames - 1) * fc + fc / 2) @(negedge clk);
        enable = 0;
        g = 0;
        while (m_run && g < 4 * fc) begin @(negedge clk); g++; end
        repeat (6) @(negedge clk);
        chk("R3 bit periods per run", rises, frames * f_nsl() * f_len());
        chk("R10 idle after stop", {bclk, fclk, sd}, 3'b000);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 reset bclk", bclk, 0);
        chk("R1 reset fclk", fclk, 0);
        chk("R1 reset sd", sd, 0);
        chk("R1 reset level", fifo_level, 0);
        chk("R1 reset underflow", underflow, 0);
        cmp_on = 1;

        // Stereo, 16-bit slots, 16-bit samples, data at the frame edge.
        sd_tag = "R5 sd stereo16";
        preload(4);
        run_frames(2);
        chk("R8 no underflow with enough data", underflow, 0);
        chk("R7 two pops per stereo frame", fifo_level, 0);

        // Overfill, then 32-bit slots, 24-bit samples, one-bit delay.
        do_reset();
        c_slot32 = 1; c_dsize = 1; c_i2s = 1; c_rise = 0; c_div = 2;
        sd_tag = "R6 sd delayed";
        preload(DEPTH + 3);
        chk("R9 full FIFO drops writes", fifo_level, DEPTH);
        run_frames(4);
        chk("R9 drained", fifo_level, 0);

        // Eight slots, sparse mask.
        do_reset();
        c_tdm = 1; c_slots = 8; c_slot32 = 1; c_dsize = 2; c_i2s = 0; c_div = 0; c_mask = 8'hA5;
        sd_tag = "R7 sd masked tdm";
        preload(8);
        run_frames(1);
        chk("R7 masked slots do not pop", fifo_level, 4);

        // Four slots, 16-bit slots truncating 32-bit samples, delayed.
        do_reset();
        c_slots = 4; c_slot32 = 0; c_dsize = 2; c_i2s = 1; c_rise = 1; c_div = 1; c_mask = 8'h06;
        sd_tag = "R5 sd truncated";
        preload(6);
        run_frames(2);
        chk("R7 level after four-slot run", fifo_level, 2);

        // Empty FIFO: underflow.
        do_reset();
        c_tdm = 0; c_dsize = 0; c_i2s = 0; c_mask = 8'h03;
        sd_tag = "R8 sd zeros on underflow";
        run_frames(1);
        chk("R8 underflow raised", underflow, 1);
        repeat (20) @(negedge clk);
        chk("R8 underflow sticky", underflow, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule